// File: doc/BRIEF.md
# Synchronous Serial Port (Master/Slave)

This block moves one byte at a time over a clocked serial link. As master it makes the serial clock itself from the system clock through a reloadable divider. As slave it follows a serial clock and an active-low select that an outside device drives. In both roles the idle clock level (CPOL) and the edge pairing (CPHA) are set by configuration inputs, and so is the bit order. Transmit and receive share one shift register. A finished byte is copied into a receive buffer and raises a completion flag, which can also drive an interrupt.

Software starts a master transfer by writing the transmit register. A write that arrives while a master transfer is running is dropped and raises a collision flag. One flag-clear strobe clears both the completion flag and the collision flag. When the master finishes, it drives its data line high so that a plain asynchronous receiver sees an idle line. As slave, the port shifts only while selected, and it drives its data line only when slave transmit is enabled. Clearing the global enable stops the port at once and releases its pins.

Top module: `sync_serial_port`

## Requirements
- R1: In master mode with the port enabled and idle, a write strobe on `tx_wr` loads the shift register and starts a transfer. The half-bit period is `cfg_baud_reload`+1 system clocks, and the first clock toggle follows the write edge by exactly one half-bit period.
- R2: Between transfers `sck_o` rests at `cfg_cpol`. During a master transfer it toggles exactly 16 times, once per half-bit, and ends at `cfg_cpol`.
- R3: With CPHA=0, the first data bit is on `sdo` from the write onward. Data is sampled on odd-numbered clock toggles and changes on even-numbered ones. With CPHA=1, data changes on odd-numbered toggles from the third onward and is sampled on even-numbered toggles.
- R4: `cfg_lsb_first`=1 sends and assembles bit 0 first. `cfg_lsb_first`=0 sends and assembles bit 7 first.
- R5: On the 16th half-bit event the received byte appears on `rx_data` and `done_flag` is set. In master mode this happens 16×(reload+1) clocks after the write. `irq` equals `done_flag` AND `cfg_irq_en`.
- R6: A master holds the last bit on `sdo` for one full bit time and then drives `sdo` to 1. With CPHA=0 this is at 16 half-bits after the write, and with CPHA=1 at 17 half-bits. `sdo` stays 1 while the master is idle.
- R7: A pulse on `flag_clr` clears `done_flag` and `coll_flag`.
- R8: A write during a running master transfer is ignored: the waveform on `sck_o`/`sdo` and the received byte are unchanged, and `coll_flag` is set.
- R9: In slave mode, while `sel_n` is low, the port shifts on edges of `sck_i`. The edges are synchronized through two flops, and CPOL, CPHA and bit order apply as in R3/R4. After 8 bits `rx_data` holds the byte read from `sdi` and `done_flag` is set.
- R10: `sdo_oe` is 1 in master mode. In slave mode it is 1 only while the port is selected and `cfg_slave_tx_en`=1, and 0 otherwise.
- R11: In slave mode, while `sel_n` is high, clock edges are ignored: the shift register keeps its contents and no completion is flagged.
- R12: `cfg_enable`=0 aborts any transfer. One clock later the port is idle, `sck_o` is at CPOL, and `sck_oe`, `sdo_oe` and `func_active` are 0. No completion is flagged, and a later write starts a new transfer without a collision.
- R13: After reset `rx_data`=0 and `done_flag`, `coll_flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Global enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Edge pairing select |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_slave_tx_en | input | 1 | Slave drives its data output |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_baud_reload | input | BAUD_W | Divider reload; half-bit = value+1 clocks |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_wdata | input | DATA_W | Transmit byte |
| flag_clr | input | 1 | Clears completion and collision flags |
| rx_data | output | DATA_W | Receive buffer |
| done_flag | output | 1 | Transfer complete |
| coll_flag | output | 1 | Write collision |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| sdi | input | 1 | Serial data in |
| sel_n | input | 1 | Slave select, active low |
| func_active | output | 1 | Pins are owned by the port |

## Verification
The hardest cases to reach are a write that lands in the middle of a running master transfer and a slave that sees clock edges while it is deselected. Neither changes the output directly. The bench therefore compares the whole master waveform every clock against a timing model based on half-bit counts. It injects the colliding write at a fixed half-bit, and it expects the waveform to be unchanged bit for bit. For the deselected case it toggles the clock while the slave is not selected, then selects the slave and reads the byte back on `sdo`. This shows whether any bit was shifted.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // Role of one half-bit event in the exchange sequence
    typedef struct packed {
        logic sample;   // capture the input bit
        logic shift;    // move the register by one bit
        logic last;     // final event of the byte
    } ssp_ev_t;

endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic [BAUD_W-1:0] reload,
    output logic              tick
);

    logic [BAUD_W-1:0] cnt_d, cnt_q;

    assign tick = run && !load && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || load || tick) begin
            cnt_d = reload;
        end else begin
            cnt_d = cnt_q - BAUD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;

endmodule

// File: rtl/ssp_phase.sv
module ssp_phase
    import ssp_pkg::*;
#(
    parameter int HCNT_W = 5,
    parameter int LAST   = 16
) (
    input  logic [HCNT_W-1:0] idx,
    input  logic              cpha,
    output ssp_ev_t           kind
);

    logic lead;

    always_comb begin
        lead        = idx[0];
        kind.sample = cpha ? !lead : lead;
        kind.shift  = !kind.sample && !(cpha && (idx == HCNT_W'(1)));
        kind.last   = (idx == HCNT_W'(LAST));
    end

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic              cfg_slave_tx_en,
    input  logic              cfg_irq_en,
    input  logic [BAUD_W-1:0] cfg_baud_reload,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              done_flag,
    output logic              coll_flag,
    output logic              irq,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi,
    input  logic              sel_n,
    output logic              func_active
);

    localparam int                 NUM_EV = 2 * DATA_W;
    localparam int                 HCNT_W = $clog2(NUM_EV + 1);
    localparam logic [HCNT_W-1:0]  LAST   = HCNT_W'(NUM_EV);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rxbuf;
        logic              rxbit;
        logic [HCNT_W-1:0] hcnt;
        logic              busy;
        logic              sck;
        logic              sdo;
        logic              done;
        logic              coll;
        logic              sck_prev;
    } st_t;

    localparam st_t RST = '{sh: '0, rxbuf: '0, rxbit: 1'b0, hcnt: '0,
                            busy: 1'b0, sck: 1'b0, sdo: 1'b1, done: 1'b0,
                            coll: 1'b0, sck_prev: 1'b0};

    st_t q, n;

    function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                   input logic b, input logic lsbf);
        return lsbf ? {b, v[DATA_W-1:1]} : {v[DATA_W-2:0], b};
    endfunction

    function automatic logic out_bit(input logic [DATA_W-1:0] v, input logic lsbf);
        return lsbf ? v[0] : v[DATA_W-1];
    endfunction

    // Slave-side pins brought into the system clock domain
    logic [2:0] pins_s;
    logic       sck_s, sel_s, sdi_s;

    ssp_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sdi, sel_n, sck_i}),
        .q     (pins_s)
    );
    assign {sdi_s, sel_s, sck_s} = pins_s;

    // Control decode
    logic start, coll_set, slv_sel, lead_edge, trail_edge;
    logic tick, m_ev, m_tail, s_ev, ev, din;
    logic [HCNT_W-1:0] idx;
    ssp_ev_t kind;

    assign start      = cfg_enable && cfg_master && tx_wr && !q.busy;
    assign coll_set   = cfg_enable && cfg_master && tx_wr && q.busy;
    assign slv_sel    = cfg_enable && !cfg_master && !sel_s;
    assign lead_edge  = (sck_s != cfg_cpol) && (q.sck_prev == cfg_cpol);
    assign trail_edge = (sck_s == cfg_cpol) && (q.sck_prev != cfg_cpol);
    assign m_ev       = q.busy && tick && (q.hcnt < LAST);
    assign m_tail     = q.busy && tick && (q.hcnt == LAST);
    assign s_ev       = slv_sel && (lead_edge || trail_edge);
    assign ev         = m_ev || s_ev;
    assign idx        = q.hcnt + HCNT_W'(1);
    assign din        = cfg_master ? sdi : sdi_s;

    ssp_baud #(.BAUD_W(BAUD_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (q.busy && cfg_enable),
        .load   (start),
        .reload (cfg_baud_reload),
        .tick   (tick)
    );

    ssp_phase #(.HCNT_W(HCNT_W), .LAST(NUM_EV)) u_phase (
        .idx  (idx),
        .cpha (cfg_cpha),
        .kind (kind)
    );

    always_comb begin
        n = q;
        n.sck_prev = sck_s;
        if (flag_clr) begin
            n.done = 1'b0;
            n.coll = 1'b0;
        end
        if (!cfg_enable) begin
            n.busy = 1'b0;
            n.hcnt = '0;
            n.sck  = cfg_cpol;
            n.sdo  = 1'b1;
        end else begin
            if (!q.busy) n.sck = cfg_cpol;
            if (cfg_master) begin
                if (start) begin
                    n.sh   = tx_wdata;
                    n.busy = 1'b1;
                    n.hcnt = '0;
                    n.sck  = cfg_cpol;
                    n.sdo  = out_bit(tx_wdata, cfg_lsb_first);
                end
                if (coll_set) n.coll = 1'b1;
            end else begin
                if (tx_wr)    n.sh   = tx_wdata;
                if (!slv_sel) n.hcnt = '0;
            end
            if (ev) begin
                n.hcnt = idx;
                if (m_ev)        n.sck   = !q.sck;
                if (kind.sample) n.rxbit = din;
                if (kind.shift) begin
                    n.sh  = shift_in(q.sh, q.rxbit, cfg_lsb_first);
                    n.sdo = out_bit(n.sh, cfg_lsb_first);
                end
                if (kind.last) begin
                    if (cfg_cpha) n.sh = shift_in(q.sh, din, cfg_lsb_first);
                    n.rxbuf = n.sh;
                    n.done  = 1'b1;
                    if (!cfg_master) n.hcnt = '0;
                    if (cfg_master && !cfg_cpha) begin
                        n.busy = 1'b0;
                        n.sdo  = 1'b1;
                        n.hcnt = '0;
                    end
                end
            end
            if (m_tail) begin
                n.busy = 1'b0;
                n.sdo  = 1'b1;
                n.hcnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= n;
    end

    assign rx_data     = q.rxbuf;
    assign done_flag   = q.done;
    assign coll_flag   = q.coll;
    assign irq         = q.done && cfg_irq_en;
    assign sck_o       = q.sck;
    assign sck_oe      = cfg_enable && cfg_master;
    assign sdo         = cfg_master ? q.sdo : out_bit(q.sh, cfg_lsb_first);
    assign sdo_oe      = cfg_enable && (cfg_master || (cfg_slave_tx_en && !sel_s));
    assign func_active = cfg_enable;

    // Assertions
    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_master && !q.busy && !start) |=> (sck_o == $past(cfg_cpol))); // R2
    AST_SDO_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_master && !q.busy) |-> sdo); // R6
    AST_COLLISION_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_master && q.busy && tx_wr) |=> coll_flag); // R8
    AST_DESELECT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !cfg_master && sel_s && !tx_wr) |=> $stable(q.sh)); // R11
    AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !q.busy); // R12
    AST_HCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.hcnt <= LAST); // R5

endmodule

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 0, cfg_master = 1, cfg_cpol = 0, cfg_cpha = 0;
    logic       cfg_lsb_first = 0, cfg_slave_tx_en = 0, cfg_irq_en = 0;
    logic [7:0] cfg_baud_reload = 8'd1;
    logic       tx_wr = 0;
    logic [7:0] tx_wdata = 8'h00;
    logic       flag_clr = 0;
    logic [7:0] rx_data;
    logic       done_flag, coll_flag, irq;
    logic       sck_i = 0, sck_o, sck_oe, sdo, sdo_oe, sdi = 0, sel_n = 1, func_active;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    sync_serial_port u_sync_serial_port (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(cfg_enable), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_slave_tx_en(cfg_slave_tx_en), .cfg_irq_en(cfg_irq_en),
        .cfg_baud_reload(cfg_baud_reload),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .flag_clr(flag_clr),
        .rx_data(rx_data), .done_flag(done_flag), .coll_flag(coll_flag), .irq(irq),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi), .sel_n(sel_n),
        .func_active(func_active)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    function automatic logic pick(input logic [7:0] b, input int i, input logic lsbf);
        return lsbf ? b[i] : b[7-i];
    endfunction

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // Master transfer compared every clock against a half-bit timing model
    task automatic run_master(input logic [7:0] txb, input logic [7:0] rxb,
                              input logic cpol, input logic cpha, input logic lsbf,
                              input int nrl, input logic ien, input logic collide);
        int h, endo, t, bi, k;
        logic e_sck, e_sdo;
        h = nrl + 1;
        endo = cpha ? 17 * h : 16 * h;
        cfg_master = 1; cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsbf;
        cfg_irq_en = ien; cfg_baud_reload = 8'(nrl);
        idle(2);
        pulse_clr();
        tx_wdata = txb; tx_wr = 1'b1; sdi = pick(rxb, 0, lsbf);
        @(negedge clk);
        tx_wr = 1'b0;
        for (int o = 0; o <= endo + 2; o++) begin
            t = o / h;
            e_sck = cpol ^ ((t > 16) ? 1'b0 : t[0]);
            if (o >= endo) e_sdo = 1'b1;
            else begin
                if (!cpha) bi = t / 2;
                else bi = (t < 3) ? 0 : (t - 1) / 2;
                e_sdo = pick(txb, bi, lsbf);
            end
            chk((o < h) ? "R1" : "R2", "sck_o", 32'(sck_o), 32'(e_sck));
            chk((o >= endo) ? "R6" : (lsbf ? "R4" : "R3"), "sdo", 32'(sdo), 32'(e_sdo));
            chk("R5", "done_flag", 32'(done_flag), 32'(o >= 16 * h));
            k = 0;
            for (int j = 0; j < 8; j++)
                if ((cpha ? (2 * j + 2) * h : (2 * j + 1) * h) <= o) k++;
            sdi = (k < 8) ? pick(rxb, k, lsbf) : 1'b0;
            if (collide && o == 3 * h) begin tx_wdata = ~txb; tx_wr = 1'b1; end
            if (collide && o == 3 * h + 1) tx_wr = 1'b0;
            @(negedge clk);
        end
        chk(lsbf ? "R4" : "R5", "rx_data", 32'(rx_data), 32'(rxb));
        chk("R5", "irq", 32'(irq), 32'(ien));
        chk("R8", "coll_flag", 32'(coll_flag), 32'(collide));
        chk("R10", "master sdo_oe", 32'(sdo_oe), 32'd1);
    endtask

    // Slave transfer with the bench acting as the clocking device
    task automatic run_slave(input logic [7:0] txb, input logic [7:0] rxb,
                             input logic cpol, input logic cpha, input logic lsbf,
                             input logic txen, input logic load);
        cfg_master = 0; cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsbf;
        cfg_slave_tx_en = txen; cfg_irq_en = 1;
        sck_i = cpol; sel_n = 1'b1;
        idle(8);
        if (load) begin
            tx_wdata = txb; tx_wr = 1'b1;
            @(negedge clk);
            tx_wr = 1'b0;
        end
        pulse_clr();
        sel_n = 1'b0;
        idle(8);
        chk("R10", "slave sdo_oe selected", 32'(sdo_oe), 32'(txen));
        for (int i = 0; i < 8; i++) begin
            if (!cpha) begin
                sdi = pick(rxb, i, lsbf);
                idle(8);
                if (txen) chk("R9", "slave sdo cpha0", 32'(sdo), 32'(pick(txb, i, lsbf)));
                sck_i = ~cpol; idle(8);
                sck_i = cpol;  idle(8);
            end else begin
                sck_i = ~cpol; idle(8);
                sdi = pick(rxb, i, lsbf);
                if (txen) chk("R9", "slave sdo cpha1", 32'(sdo), 32'(pick(txb, i, lsbf)));
                idle(8);
                sck_i = cpol; idle(8);
            end
        end
        idle(4);
        chk("R9", "slave done_flag", 32'(done_flag), 32'd1);
        chk("R9", "slave rx_data", 32'(rx_data), 32'(rxb));
        sel_n = 1'b1;
        idle(8);
        chk("R10", "slave sdo_oe deselected", 32'(sdo_oe), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        chk("R13", "rx_data", 32'(rx_data), 32'd0);
        chk("R13", "done_flag", 32'(done_flag), 32'd0);
        chk("R13", "coll_flag", 32'(coll_flag), 32'd0);
        chk("R13", "irq", 32'(irq), 32'd0);
        chk("R12", "func_active off", 32'(func_active), 32'd0);

        cfg_enable = 1'b1;
        run_master(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 1, 1'b1, 1'b0);
        run_master(8'h96, 8'hE1, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b0);
        run_master(8'h5A, 8'h0F, 1'b0, 1'b1, 1'b0, 2, 1'b1, 1'b1);
        run_master(8'hC3, 8'h81, 1'b1, 1'b1, 1'b1, 3, 1'b0, 1'b0);

        // R7: flags clear
        cfg_irq_en = 1'b1;
        tx_wdata = 8'h11; tx_wr = 1'b1; @(negedge clk);
        tx_wdata = 8'h22; @(negedge clk);
        tx_wr = 1'b0;
        idle(80);
        chk("R7", "flags before clear", 32'({done_flag, coll_flag}), 32'b11);
        pulse_clr();
        chk("R7", "done after clear", 32'(done_flag), 32'd0);
        chk("R7", "coll after clear", 32'(coll_flag), 32'd0);
        chk("R7", "irq after clear", 32'(irq), 32'd0);

        // R12: abort by disable
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_baud_reload = 8'd2;
        tx_wdata = 8'h55; tx_wr = 1'b1; @(negedge clk);
        tx_wr = 1'b0;
        idle(10);
        cfg_enable = 1'b0;
        @(negedge clk);
        chk("R12", "sck_oe", 32'(sck_oe), 32'd0);
        chk("R12", "sdo_oe", 32'(sdo_oe), 32'd0);
        chk("R12", "func_active", 32'(func_active), 32'd0);
        chk("R12", "sck_o at cpol", 32'(sck_o), 32'd0);
        idle(60);
        chk("R12", "no done after abort", 32'(done_flag), 32'd0);
        cfg_enable = 1'b1;
        run_master(8'h7E, 8'h42, 1'b0, 1'b0, 1'b0, 2, 1'b0, 1'b0);

        // Slave role
        run_slave(8'h69, 8'hB4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        run_slave(8'h2D, 8'hD2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        run_slave(8'h71, 8'h8E, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);

        // R11: edges while deselected leave the register intact
        cfg_master = 0; cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 0;
        cfg_slave_tx_en = 1; sel_n = 1'b1; sck_i = 1'b0;
        idle(8);
        tx_wdata = 8'h3C; tx_wr = 1'b1; @(negedge clk);
        tx_wr = 1'b0;
        pulse_clr();
        for (int j = 0; j < 6; j++) begin
            sdi = j[0];
            sck_i = 1'b1; idle(8);
            sck_i = 1'b0; idle(8);
        end
        chk("R11", "no done while deselected", 32'(done_flag), 32'd0);
        chk("R11", "sdo_oe while deselected", 32'(sdo_oe), 32'd0);
        run_slave(8'h3C, 8'hC5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule